// File: doc/BRIEF.md
# Execution Unit Pool Allocator

This block owns a small pool of execution units split into operation classes and hands them out to an issue stage. Each cycle every request port may ask for one unit of a given class; the block answers per port with a status code and, on a grant, a global unit index. Class 0 stands for operations that need no execution unit at all and is always accepted without reserving anything. Failed requests are counted per class.

Units come back to the pool on two different schedules. A unit given to a single-cycle operation, or to a multi-cycle operation on a fully pipelined unit, is free again in the very next cycle. A unit given to a multi-cycle operation on a non-pipelined unit stays reserved. A per-unit timer then raises a completion strobe a fixed number of cycles later, and the unit returns to the pool one cycle after that strobe. Class count, units per class, number of request ports and each class's operation and issue latencies are parameters.

Top module: `fu_pool_alloc`

## Requirements
- R1: A port whose request valid is low reports status 0 (idle). The other status codes are 1 = unit granted, 2 = no unit of the class free, 3 = no unit needed.
- R2: A valid request for class 0 always returns status 3, reserves no unit and leaves every unit available to other ports in the same cycle.
- R3: A granted unit belongs to the requested class, whose units carry global indices (class-1)*UNITS_PER_CLASS up to class*UNITS_PER_CLASS-1, and it is the lowest-indexed unit of that class still free for that port.
- R4: Port p sees the grants made to ports 0..p-1 in the same cycle, so no two ports receive the same unit in one cycle.
- R5: A valid request that finds no free unit of its class returns status 2. The busy counter of that class (field c of busy_cnt_o, CNT_W bits, class 0 at the lowest bits) increases by the number of such ports, visible the next cycle.
- R6: A unit granted for a class with operation latency 1 is unavailable for the rest of the grant cycle and available again in the next cycle.
- R7: A unit granted for a class with operation latency above 1 and issue latency 1 (pipelined) is available again in the next cycle and raises no completion strobe.
- R8: A unit granted in cycle t for a class with operation latency and issue latency both above 1 raises done_o[unit] for one cycle, in cycle t + issue_latency - 1. It is unavailable from cycle t up to and including that cycle, and available from the following cycle.
- R9: After reset all units are free, all busy counters are zero and no completion strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | NUM_PORTS | Request valid per port |
| req_class_i | input | NUM_PORTS*CW | Requested class per port, port p at bits p*CW |
| grant_code_o | output | NUM_PORTS*2 | Status code per port (R1) |
| grant_unit_o | output | NUM_PORTS*UW | Granted global unit index per port, valid with status 1 |
| done_o | output | NU | Completion strobe per unit for non-pipelined operations |
| busy_cnt_o | output | NUM_CLASSES*CNT_W | Per-class count of requests refused for lack of a unit |

## Verification
The default configuration has three unit classes, two units each and two ports: one single-cycle class, one pipelined multi-cycle class and one non-pipelined class with issue latency 3. Directed sequences come first. Same-class pairs on both ports separate lowest-first picking and port ordering. Back-to-back identical requests separate next-cycle release from a late release. A non-pipelined burst pins the strobe cycle and the return cycle. A class-0 request next to a real one shows that nothing is reserved. A long pseudo-random sweep then covers all 64 combinations of valid and class on both ports against an arithmetic pool model, which catches wrong refusals, stolen units and miscounted busy events under overlapping timers.

// File: rtl/fu_pool_pkg.sv
package fu_pool_pkg;
  typedef enum logic [1:0] {
    FU_IDLE   = 2'd0,
    FU_GRANT  = 2'd1,
    FU_BUSY   = 2'd2,
    FU_NOUNIT = 2'd3
  } fu_code_e;
endpackage

// File: rtl/fu_port_arb.sv
module fu_port_arb
  import fu_pool_pkg::*;
#(
  parameter int NUM_CLASSES     = 4,
  parameter int UNITS_PER_CLASS = 2,
  parameter int NU              = (NUM_CLASSES - 1) * UNITS_PER_CLASS,
  parameter int CW              = $clog2(NUM_CLASSES),
  parameter int UW              = (NU > 1) ? $clog2(NU) : 1
) (
  input  logic          valid_i,
  input  logic [CW-1:0] class_i,
  input  logic [NU-1:0] avail_i,
  output fu_code_e      code_o,
  output logic [UW-1:0] unit_o,
  output logic [NU-1:0] take_o
);
  int base;
  int hit;

  always_comb begin
    code_o = FU_IDLE;
    unit_o = '0;
    take_o = '0;
    base   = 0;
    hit    = -1;
    if (valid_i && int'(class_i) < NUM_CLASSES) begin
      if (class_i == '0) begin
        code_o = FU_NOUNIT;
      end else begin
        base = (int'(class_i) - 1) * UNITS_PER_CLASS;
        // descending scan: lowest free index wins
        for (int k = UNITS_PER_CLASS - 1; k >= 0; k--) begin
          if (avail_i[base + k]) hit = base + k;
        end
        if (hit >= 0) begin
          code_o       = FU_GRANT;
          unit_o       = UW'(hit);
          take_o[hit]  = 1'b1;
        end else begin
          code_o = FU_BUSY;
        end
      end
    end
  end
endmodule

// File: rtl/fu_unit_timer.sv
module fu_unit_timer #(
  parameter int LAT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LAT_W-1:0] load_val_i,
  output logic             fire_o
);
  logic [LAT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign fire_o = (cnt_q == LAT_W'(1));

  // R8
  timer_single_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o && !load_i |=> !fire_o);
endmodule

// File: rtl/fu_pool_alloc.sv
module fu_pool_alloc
  import fu_pool_pkg::*;
#(
  parameter int NUM_CLASSES     = 4,
  parameter int UNITS_PER_CLASS = 2,
  parameter int NUM_PORTS       = 2,
  parameter int LAT_W           = 8,
  parameter int CNT_W           = 16,
  parameter logic [NUM_CLASSES*LAT_W-1:0] OP_LAT  = {8'd4, 8'd3, 8'd1, 8'd0},
  parameter logic [NUM_CLASSES*LAT_W-1:0] ISS_LAT = {8'd3, 8'd1, 8'd1, 8'd0},
  localparam int CW = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1,
  localparam int NU = (NUM_CLASSES - 1) * UNITS_PER_CLASS,
  localparam int UW = (NU > 1) ? $clog2(NU) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_PORTS-1:0]         req_valid_i,
  input  logic [NUM_PORTS*CW-1:0]      req_class_i,
  output logic [NUM_PORTS*2-1:0]       grant_code_o,
  output logic [NUM_PORTS*UW-1:0]      grant_unit_o,
  output logic [NU-1:0]                done_o,
  output logic [NUM_CLASSES*CNT_W-1:0] busy_cnt_o
);
  logic [NU-1:0]    free_q, free_d;
  logic [NU-1:0]    avail [NUM_PORTS+1];
  logic [NU-1:0]    take  [NUM_PORTS];
  fu_code_e         code  [NUM_PORTS];
  logic [UW-1:0]    unit  [NUM_PORTS];
  logic [CW-1:0]    rcls  [NUM_PORTS];
  logic [NU-1:0]    gnt_all, np_vec, fire_vec, rel_next;
  logic [CNT_W-1:0] busy_cnt_q [NUM_CLASSES];
  logic [CNT_W-1:0] busy_inc   [NUM_CLASSES];

  assign avail[0] = free_q;

  // Port chain: each port allocates from what lower ports left
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign rcls[p] = req_class_i[p*CW +: CW];

    fu_port_arb #(
      .NUM_CLASSES(NUM_CLASSES), .UNITS_PER_CLASS(UNITS_PER_CLASS),
      .NU(NU), .CW(CW), .UW(UW)
    ) u_arb (
      .valid_i (req_valid_i[p]),
      .class_i (rcls[p]),
      .avail_i (avail[p]),
      .code_o  (code[p]),
      .unit_o  (unit[p]),
      .take_o  (take[p])
    );

    assign avail[p+1]            = avail[p] & ~take[p];
    assign grant_code_o[p*2 +: 2] = code[p];
    assign grant_unit_o[p*UW +: UW] = unit[p];

    // R3
    grant_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      code[p] == FU_GRANT |-> free_q[unit[p]]
        && (int'(unit[p]) / UNITS_PER_CLASS + 1 == int'(rcls[p])));
    // R2
    nounit_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      code[p] == FU_NOUNIT |-> req_valid_i[p] && rcls[p] == '0);
    // R1
    idle_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_valid_i[p] |-> code[p] == FU_IDLE);
    // R6 R7
    pipe_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      code[p] == FU_GRANT && !np_vec[unit[p]] |=> free_q[$past(unit[p])]);

    for (genvar q = p + 1; q < NUM_PORTS; q++) begin : g_pair
      // R4
      distinct_unit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        code[p] == FU_GRANT && code[q] == FU_GRANT |-> unit[p] != unit[q]);
    end
  end

  always_comb begin
    gnt_all = '0;
    for (int p = 0; p < NUM_PORTS; p++) gnt_all |= take[p];
  end

  // Per-unit release schedule chosen from the class latencies
  for (genvar u = 0; u < NU; u++) begin : g_unit
    localparam int CLS = u / UNITS_PER_CLASS + 1;
    localparam int OPL = int'(OP_LAT[CLS*LAT_W +: LAT_W]);
    localparam int ISL = int'(ISS_LAT[CLS*LAT_W +: LAT_W]);
    if (OPL > 1 && ISL > 1) begin : g_np
      assign np_vec[u] = 1'b1;
      fu_unit_timer #(.LAT_W(LAT_W)) u_tmr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (gnt_all[u]),
        .load_val_i (LAT_W'(ISL - 1)),
        .fire_o     (fire_vec[u])
      );
      // R8
      fire_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire_vec[u] |-> !free_q[u] ##1 free_q[u]);
    end else begin : g_pipe
      assign np_vec[u]   = 1'b0;
      assign fire_vec[u] = 1'b0;
    end
  end

  // Pending-free mask: pipelined/single-cycle grants return at the edge
  assign rel_next = gnt_all & ~np_vec;
  assign free_d   = (free_q & ~gnt_all) | rel_next | fire_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) free_q <= '1;
    else         free_q <= free_d;
  end

  assign done_o = fire_vec;

  always_comb begin
    for (int c = 0; c < NUM_CLASSES; c++) begin
      busy_inc[c] = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (code[p] == FU_BUSY && rcls[p] == CW'(c)) busy_inc[c] = busy_inc[c] + 1'b1;
      end
    end
  end

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) busy_cnt_q[c] <= '0;
      else         busy_cnt_q[c] <= busy_cnt_q[c] + busy_inc[c];
    end
    assign busy_cnt_o[c*CNT_W +: CNT_W] = busy_cnt_q[c];

    // R5
    busy_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_inc[c] != '0 |=> busy_cnt_q[c] != $past(busy_cnt_q[c]));
  end
endmodule

// File: tb/tb_fu_pool_alloc.sv
`timescale 1ns/1ps
module tb_fu_pool_alloc;
  localparam int NC = 4, UPC = 2, P = 2, NU = 6, UW = 3, CW = 2, CNT_W = 16;
  localparam int OPL [NC] = '{0, 1, 3, 4};
  localparam int ISL [NC] = '{0, 1, 1, 3};

  logic clk = 0, rst_n = 0;
  logic [P-1:0]          req_valid;
  logic [P*CW-1:0]       req_class;
  logic [P*2-1:0]        grant_code;
  logic [P*UW-1:0]       grant_unit;
  logic [NU-1:0]         done;
  logic [NC*CNT_W-1:0]   busy_cnt;

  always #4 clk = ~clk;

  fu_pool_alloc dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_class_i(req_class),
    .grant_code_o(grant_code), .grant_unit_o(grant_unit), .done_o(done), .busy_cnt_o(busy_cnt)
  );

  int checks = 0, errors = 0;
  int m_free [NU];
  int m_tmr  [NU];
  int m_cnt  [NC];

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int code_of(input int p);
    return int'(grant_code[p*2 +: 2]);
  endfunction
  function automatic int unit_of(input int p);
    return int'(grant_unit[p*UW +: UW]);
  endfunction

  task automatic model_reset();
    for (int u = 0; u < NU; u++) begin m_free[u] = 1; m_tmr[u] = 0; end
    for (int c = 0; c < NC; c++) m_cnt[c] = 0;
  endtask

  // Drive one cycle, compare against pool model, advance model across the edge
  task automatic step(input bit v0, input int c0, input bit v1, input int c1);
    int vv [P];
    int cc [P];
    int taken [NU];
    int ecode [P];
    int eunit [P];
    int fire  [NU];
    int edone;
    vv[0] = int'(v0); cc[0] = c0; vv[1] = int'(v1); cc[1] = c1;
    @(negedge clk);
    req_valid = {v1, v0};
    req_class = {CW'(c1), CW'(c0)};
    #1;
    for (int u = 0; u < NU; u++) taken[u] = 0;
    for (int p = 0; p < P; p++) begin
      ecode[p] = 0; eunit[p] = -1;
      if (vv[p] == 1) begin
        if (cc[p] == 0) ecode[p] = 3;
        else begin
          ecode[p] = 2;
          for (int k = 0; k < UPC; k++) begin
            int u = (cc[p] - 1) * UPC + k;
            if (eunit[p] < 0 && m_free[u] == 1 && taken[u] == 0) eunit[p] = u;
          end
          if (eunit[p] >= 0) begin ecode[p] = 1; taken[eunit[p]] = 1; end
        end
      end
    end
    for (int p = 0; p < P; p++) begin
      case (ecode[p])
        0: check(code_of(p), 0, "R1 idle code");
        3: check(code_of(p), 3, "R2 nounit code");
        2: check(code_of(p), 2, "R5 busy code");
        default: begin
          check(code_of(p), 1, p == 0 ? "R3 grant code" : "R4 grant code");
          if (code_of(p) == 1)
            check(unit_of(p), eunit[p], p == 0 ? "R3 lowest unit" : "R4 port order unit");
        end
      endcase
    end
    edone = 0;
    for (int u = 0; u < NU; u++) begin
      fire[u] = (m_tmr[u] == 1) ? 1 : 0;
      edone |= fire[u] << u;
    end
    check(int'(done), edone, "R8 done strobe");
    for (int c = 0; c < NC; c++)
      check(int'(busy_cnt[c*CNT_W +: CNT_W]), m_cnt[c], "R5 busy count");
    // edge update
    for (int p = 0; p < P; p++) if (ecode[p] == 2) m_cnt[cc[p]] = (m_cnt[cc[p]] + 1) % 65536;
    for (int u = 0; u < NU; u++) if (m_tmr[u] != 0) m_tmr[u]--;
    for (int u = 0; u < NU; u++) begin
      int cls = u / UPC + 1;
      if (taken[u] == 1 && OPL[cls] > 1 && ISL[cls] > 1) begin
        m_free[u] = 0; m_tmr[u] = ISL[cls] - 1;
      end
      if (fire[u] == 1) m_free[u] = 1;
    end
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    req_valid = '0; req_class = '0;
    model_reset();
    #20 rst_n = 1;
    @(negedge clk);
    // R9 reset state
    check(int'(grant_code), 0, "R9 reset codes");
    check(int'(done), 0, "R9 reset done");
    check(int'(busy_cnt != '0), 0, "R9 reset counters");

    // R3 R4: both ports class 1 take units 0 then 1
    step(1, 1, 1, 1);
    check(unit_of(0), 0, "R3 port0 lowest");
    check(unit_of(1), 1, "R4 port1 next");
    // R6: same units free again next cycle
    step(1, 1, 1, 1);
    check(code_of(0), 1, "R6 reissue code");
    check(unit_of(0), 0, "R6 reissue unit");
    // R7: pipelined class returns next cycle, no strobe
    step(1, 2, 1, 2);
    step(1, 2, 1, 2);
    check(unit_of(1), 3, "R7 pipelined reissue");
    check(int'(done), 0, "R7 no strobe");
    // R2: class 0 reserves nothing
    step(1, 0, 1, 1);
    check(code_of(0), 3, "R2 nounit");
    check(unit_of(1), 0, "R2 unit 0 still free");
    // R8: non-pipelined hold, strobe at t+2, free at t+3
    step(1, 3, 1, 3);
    step(1, 3, 0, 0);
    check(code_of(0), 2, "R8 held busy");
    step(1, 3, 0, 0);
    check(int'(done), 6'b110000, "R8 strobe cycle");
    check(code_of(0), 2, "R8 busy during strobe");
    step(1, 3, 1, 3);
    check(code_of(1), 1, "R8 returned");
    check(int'(busy_cnt[3*CNT_W +: CNT_W]), 2, "R5 count after refusals");
    step(0, 0, 0, 0);

    // sweep: all 64 valid/class combinations, pseudo-random order
    lf = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      int combo;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      combo = (i < 64) ? i : int'(lf[5:0]);
      step(combo[0], (combo >> 1) & 3, combo[3], (combo >> 4) & 3);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule